// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a 32-bit bus address into at most one of eight active-low chip-select lines. Each channel holds a 16-bit base, a 16-bit per-bit mask and two control flags, write-protect and valid. All of them are loaded through a small register write port. A channel matches when the upper half of the address equals its base in every bit position where the mask is clear. A set mask bit widens the region, so a channel with n mask bits set spans 2^(n+16) bytes.

Channel 0 comes out of reset as a catch-all select, so a boot memory answers before software has set anything up. Once its valid flag is set, it decodes like any other channel. A write that lands in a valid, write-protected region selects nothing and produces a one-cycle access-error pulse instead.

Decoding is registered. The select lines and the error pulse appear one clock after the cycle in which the address strobe is high.

Top module: `csd_top`

## Requirements
- R1: After reset every `cs_n` bit is 1, `acc_err` is 0, and every channel has its valid and write-protect flags cleared with base and mask 0.
- R2: While channel 0's valid flag is 0, any strobed read or write selects channel 0 (`cs_n` = 8'hFE), whatever the other channels hold.
- R3: A channel matches when `bus_addr[31:16]` equals its base in every bit whose mask bit is 0; mask bits at 1 are don't-care, giving a region of 2^(n+16) bytes for n mask bits set.
- R4: Channels 1 to 7 never assert their select while their valid flag is 0, even if the base matches.
- R5: A write that hits a valid channel with write-protect 1 leaves all `cs_n` at 1 and raises `acc_err` for exactly one cycle; reads of the same region select the channel with no error.
- R6: With write-protect 0, both reads and writes that hit a valid channel select it, with `acc_err` 0.
- R7: When several enabled channels match, only the lowest-numbered one asserts; at most one `cs_n` bit is 0 at any time.
- R8: `cs_n` and `acc_err` reflect the access strobed on the previous clock edge; a cycle without a strobe is followed by all `cs_n` at 1 and `acc_err` 0.
- R9: Once channel 0's valid flag is 1, it matches only its own region; an address that no valid channel matches gives all `cs_n` at 1 and no error.
- R10: Configuration writes use `cfg_ch` for the channel and `cfg_sel` for the register: 0 base, 1 mask, 2 control (bit 0 valid, bit 1 write-protect); a write with `cfg_sel` = 3 changes nothing.
- R11: Channel 0 with base 16'h0000 and mask 16'h01FF, and channel 1 with base 16'h0200 and mask 16'h00FF, form adjacent 32 MB and 16 MB regions with no gap and no overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_ch | input | 3 | Channel being configured |
| cfg_sel | input | 2 | Register select: 0 base, 1 mask, 2 control, 3 ignored |
| cfg_wdata | input | 16 | Configuration write data |
| bus_valid | input | 1 | Address strobe for one bus access |
| bus_write | input | 1 | 1 for a write access, 0 for a read |
| bus_addr | input | 32 | Bus byte address |
| cs_n | output | 8 | Active-low chip selects, one per channel |
| acc_err | output | 1 | One-cycle pulse on a write into a protected region |

## Verification
Priority resolution and write protection can act on the same access. A protected channel can be the lowest-numbered match while a higher channel also covers the address. The bench provokes this by overlapping a wide channel 3 with a protected channel 1. It then sweeps every upper-address value of the region with both reads and writes. Each result is judged against an arithmetic model that picks the lowest enabled match first and only then applies protection. A protected write must therefore produce the error pulse, and must never fall through to channel 3.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int CSD_CMP_W = 16;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_RSVD = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [CSD_CMP_W-1:0] base;
        logic [CSD_CMP_W-1:0] mask;
        logic                 wp;
        logic                 valid;
    } ch_cfg_t;

endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
    import csd_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CH_W-1:0]             cfg_ch,
    input  logic [1:0]                  cfg_sel,
    input  logic [CSD_CMP_W-1:0]        cfg_wdata,
    output ch_cfg_t [NUM_CH-1:0]        cfg_o
);

    ch_cfg_t [NUM_CH-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cfg_we && (32'(cfg_ch) == i)) begin
                unique case (cfg_sel_e'(cfg_sel))
                    SEL_BASE: cfg_d[i].base  = cfg_wdata;
                    SEL_MASK: cfg_d[i].mask  = cfg_wdata;
                    SEL_CTRL: begin
                        cfg_d[i].valid = cfg_wdata[0];
                        cfg_d[i].wp    = cfg_wdata[1];
                    end
                    SEL_RSVD: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/csd_match.sv
module csd_match
    import csd_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  ch_cfg_t [NUM_CH-1:0]     cfg_i,
    input  logic [CSD_CMP_W-1:0]     addr_hi,
    output logic [NUM_CH-1:0]        hit_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic region_hit;
        assign region_hit = ((addr_hi ^ cfg_i[g].base) & ~cfg_i[g].mask) == '0;
        if (g == 0) begin : g_boot
            // unconfigured channel 0 answers every address
            assign hit_o[g] = !cfg_i[g].valid || region_hit;
        end else begin : g_norm
            assign hit_o[g] = cfg_i[g].valid && region_hit;
        end
    end

endmodule

// File: rtl/csd_arbiter.sv
module csd_arbiter #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] prot_i,
    input  logic              is_write,
    output logic [NUM_CH-1:0] grant_o,
    output logic              err_o
);

    logic [NUM_CH-1:0] winner;
    logic              found;

    always_comb begin
        winner = '0;
        found  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_i[i] && !found) begin
                winner[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    assign err_o   = is_write && |(winner & prot_i);
    assign grant_o = err_o ? '0 : winner;

endmodule

// File: rtl/csd_top.sv
module csd_top
    import csd_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CH_W-1:0]       cfg_ch,
    input  logic [1:0]            cfg_sel,
    input  logic [CSD_CMP_W-1:0]  cfg_wdata,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic [NUM_CH-1:0]     cs_n,
    output logic                  acc_err
);

    typedef struct packed {
        logic [NUM_CH-1:0] cs_n;
        logic              err;
    } out_t;

    ch_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]    hit, prot, grant, ch_valid;
    logic                 err_raw;
    out_t                 out_d, out_q;

    csd_cfg_regs #(.NUM_CH(NUM_CH)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    csd_match #(.NUM_CH(NUM_CH)) match_i (
        .cfg_i   (cfg),
        .addr_hi (bus_addr[ADDR_W-1 -: CSD_CMP_W]),
        .hit_o   (hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flags
        assign ch_valid[g] = cfg[g].valid;
        assign prot[g]     = cfg[g].valid && cfg[g].wp;
    end

    csd_arbiter #(.NUM_CH(NUM_CH)) arb_i (
        .hit_i    (hit),
        .prot_i   (prot),
        .is_write (bus_write),
        .grant_o  (grant),
        .err_o    (err_raw)
    );

    always_comb begin
        out_d.cs_n = '1;
        out_d.err  = 1'b0;
        if (bus_valid) begin
            out_d.cs_n = ~grant;
            out_d.err  = err_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{cs_n: '1, err: 1'b0};
        else        out_q <= out_d;
    end

    assign cs_n    = out_q.cs_n;
    assign acc_err = out_q.err;

endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [NUM_CH-1:0] cs_n,
    input logic              acc_err,
    input logic [NUM_CH-1:0] ch_valid
);

    assert_single_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_err_no_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (cs_n == '1));

    assert_err_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(bus_valid && bus_write));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_valid) |-> (cs_n == '1 && !acc_err));

    for (genvar k = 1; k < NUM_CH; k++) begin : g_vchk
        assert_invalid_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !cs_n[k] |-> $past(ch_valid[k]));
    end

endmodule

bind csd_top csd_checker #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .cs_n      (cs_n),
    .acc_err   (acc_err),
    .ch_valid  (ch_valid)
);

// File: tb/csd_top_tb_top.sv
module csd_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  cs_n;
    logic        acc_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_base [8];
    logic [15:0] m_mask [8];
    logic        m_wp   [8];
    logic        m_val  [8];

    always #2 clk = ~clk;

    csd_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .cs_n(cs_n), .acc_err(acc_err)
    );

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got cs_n=%h err=%b, expected cs_n=%h err=%b",
                     req, act[7:0], act[8], exp[7:0], exp[8]);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    // model: lowest enabled match wins, then protection applies
    function automatic logic [8:0] model(logic [15:0] hi, logic wr);
        for (int i = 0; i < 8; i++) begin
            logic m;
            m = (((hi ^ m_base[i]) & ~m_mask[i]) == 16'h0);
            if ((i == 0 && !m_val[0]) || (m_val[i] && m)) begin
                if (wr && m_val[i] && m_wp[i]) return {1'b1, 8'hFF};
                return {1'b0, ~(8'h01 << i)};
            end
        end
        return {1'b0, 8'hFF};
    endfunction

    task automatic cfg_write(int ch, int sel, logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_base[ch] = data;
            1: m_mask[ch] = data;
            2: begin m_val[ch] = data[0]; m_wp[ch] = data[1]; end
            default: ;
        endcase
    endtask

    task automatic access(logic [15:0] hi, logic wr, string req, output logic [8:0] got);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = {hi, 16'(hi * 16'd37 + 16'd5)};
        @(negedge clk);
        bus_valid = 1'b0;
        got = {acc_err, cs_n};
        check(req, got, model(hi, wr));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        logic [8:0] g;
        int n0, n1, n3, nerr;
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_wp[i] = 1'b0; m_val[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {acc_err, cs_n}, {1'b0, 8'hFF});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {acc_err, cs_n}, {1'b0, 8'hFF});

        // R2 global boot select
        access(16'h0000, 1'b0, "R2 global read", g);
        access(16'h1234, 1'b1, "R2 global write", g);
        access(16'hFFFF, 1'b0, "R2 global top", g);
        cfg_write(1, 0, 16'h0010);
        cfg_write(1, 2, 16'h0001);
        access(16'h0010, 1'b0, "R2 R7 global beats ch1", g);
        check("R2 ch0 selected", g, {1'b0, 8'hFE});

        // R9 ch0 programmed elsewhere
        cfg_write(0, 0, 16'hFF00);
        cfg_write(0, 2, 16'h0001);
        access(16'h0010, 1'b0, "R9 ch1 now visible", g);
        check("R9 ch1 select", g, {1'b0, 8'hFD});
        access(16'h0020, 1'b1, "R9 unmatched", g);
        check("R9 no select", g, {1'b0, 8'hFF});
        access(16'hFF00, 1'b0, "R9 ch0 own region", g);

        // R4 invalid channel stays silent
        cfg_write(2, 0, 16'h0020);
        access(16'h0020, 1'b0, "R4 invalid ch2", g);
        check("R4 ch2 silent", g, {1'b0, 8'hFF});
        cfg_write(2, 2, 16'h0001);
        access(16'h0020, 1'b0, "R4 ch2 valid", g);
        check("R4 ch2 select", g, {1'b0, 8'hFB});

        // R10 reserved select ignored
        cfg_write(2, 3, 16'h0000);
        access(16'h0020, 1'b0, "R10 rsvd write ignored", g);
        check("R10 ch2 unchanged", g, {1'b0, 8'hFB});

        // R8 idle cycle
        @(negedge clk);
        check("R8 idle", {acc_err, cs_n}, {1'b0, 8'hFF});

        // R11 R3 adjacent regions
        cfg_write(2, 2, 16'h0000);
        cfg_write(1, 0, 16'h0200);
        cfg_write(1, 1, 16'h00FF);
        cfg_write(0, 0, 16'h0000);
        cfg_write(0, 1, 16'h01FF);
        n0 = 0; n1 = 0;
        for (int h = 0; h < 16'h0400; h++) begin
            access(16'(h), 1'b0, "R3 R11 adjacent sweep", g);
            if (g[7:0] == 8'hFE) n0++;
            if (g[7:0] == 8'hFD) n1++;
        end
        check_int("R11 ch0 span 32MB in 64KB units", n0, 512);
        check_int("R11 ch1 span 16MB in 64KB units", n1, 256);

        // R7 overlap: ch3 covers 0x0000..0x0FFF
        cfg_write(3, 0, 16'h0000);
        cfg_write(3, 1, 16'h0FFF);
        cfg_write(3, 2, 16'h0001);
        n3 = 0;
        for (int h = 0; h < 16'h1000; h++) begin
            access(16'(h), 1'b1, "R7 R6 overlap sweep", g);
            if (g[7:0] == 8'hF7) n3++;
        end
        check_int("R7 ch3 only above lower channels", n3, 16'h1000 - 16'h0300);

        // R5 protect ch1, overlapped by ch3
        cfg_write(1, 2, 16'h0003);
        nerr = 0;
        for (int h = 0; h < 16'h0400; h++) begin
            access(16'(h), 1'b0, "R5 protected read", g);
            access(16'(h), 1'b1, "R5 R6 protected write", g);
            if (g[8]) nerr++;
        end
        check_int("R5 error count", nerr, 256);
        access(16'h0280, 1'b1, "R5 error write", g);
        @(negedge clk);
        check("R5 pulse one cycle", {acc_err, cs_n}, {1'b0, 8'hFF});
        access(16'h0100, 1'b1, "R6 ch0 write allowed", g);
        check("R6 ch0 write", g, {1'b0, 8'hFE});

        done = 1'b1;
        finish_run();
    end

endmodule